// File: doc/BRIEF.md
# Host-Timed Flash Programming Sequencer

This block sits on the host side of a byte-wide parallel flash device that has no self-timed algorithms of its own. It drives the device's chip-enable, output-enable and write-enable strobes (all active low), the address bus and the data bus. The block carries out the full program and erase procedures itself. It writes the command bytes, times the program or erase pulse with its own counter, issues the verify command and compares the byte it reads back. On a mismatch it repeats the attempt, up to a fixed attempt limit.

A client raises `start` for one cycle with `op`. When `op` is 0 the request programs `data_in` at `addr_in`. When `op` is 1 the request erases the whole chip. An erase first programs every location to 0x00, walking upward from address 0. It then loops through erase pulses and verifies the array upward for the erased value 0xFF. After each new pulse it resumes at the first address that failed. `busy` covers the whole run. `done` pulses once at the end, and `fail` with `fail_addr` reports an exhausted attempt limit.

States:
- Idle: `S_IDLE`.
- Program attempt: `S_PSETUP`, `S_PDATA`, `S_PPULSE`, `S_PVCMD`, `S_PREAD`, `S_PCHECK`.
- Erase attempt: `S_ESETUP`, `S_ECMD`, `S_EPULSE`, `S_EVCMD`, `S_EREAD`, `S_ECHECK`.
- Completion: `S_FINISH`.

Transitions:
- idle→setup on start.
- Write and read states advance on the bus-cycle acknowledge.
- Pulse states advance on timer expiry.
- `S_PCHECK` goes to finish on a match, to `S_PSETUP` for the next address during pre-programming, to `S_ESETUP` after the last pre-programmed address, to `S_PSETUP` on a retry, or to finish on the attempt limit.
- `S_ECHECK` goes to `S_EVCMD` for the next address on a match, to finish after the last address, to `S_ESETUP` on a retry, or to finish on the attempt limit.
- finish→idle.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `fl_dq_oe` is 0, and `busy`, `done` and `fail` are 0.
- R2: Each program attempt is, in order:
  - a write of 0x40 at the target address;
  - a write of the data byte at the target address;
  - a wait of at least `T_PROG_PULSE` cycles;
  - a write of 0xC0;
  - a read of the target address compared with the data byte.
- R3: A program request succeeds at the first attempt whose read-back matches. After 25 (`PROG_TRIES`) mismatching attempts it ends with `fail`=1 and `fail_addr` equal to the address.
- R4: An erase request programs every address to 0x00 in ascending order before the first erase command is written.
- R5: Each erase attempt is a write of 0x20, a second write of 0x20, and a wait of at least `T_ERASE_PULSE` cycles. It is followed by verification, where each address checked gets a write of 0xA0 at that address, then a read compared with 0xFF.
- R6: Erase verification moves upward while bytes read 0xFF. On a mismatch a new erase attempt starts, and verification resumes at that same address. The request succeeds when the highest address reads 0xFF.
- R7: After 1000 (`ERASE_TRIES`) erase attempts without success, the request ends with `fail`=1 and `fail_addr` equal to the address that last failed.
- R8: In every write cycle `fl_oe_n` stays 1. Address and data stay stable while `fl_we_n` is 0, and `fl_we_n` is low for exactly `T_WE_LOW` cycles.
- R9: In every read cycle `fl_ce_n` and `fl_oe_n` are 0, and `fl_dq_oe` is 0.
- R10: `start` is ignored while `busy`=1. `done` is a one-cycle pulse, seen with `busy`=0. `fail` and `fail_addr` hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only in idle |
| op | input | 1 | 0 = program byte, 1 = erase chip |
| addr_in | input | ADDR_W | Target address for program |
| data_in | input | DATA_W | Byte to program |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Attempt limit exhausted on the last request |
| fail_addr | output | ADDR_W | Address where the limit was exhausted |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | DATA_W | Data driven to flash |
| fl_dq_oe | output | 1 | Engine drives the data bus |
| fl_dq_in | input | DATA_W | Data read from flash |

## Verification
The assertions check bus-level rules on every cycle:
- `fl_oe_n` stays high during writes, and the data bus is not driven during reads.
- Address and data are stable across the write strobe, and the strobe width is exact.
- `done` is a single-cycle pulse, and the attempt counters stay bounded.

Only the bench's scenarios can show the command order and the attempt counts. That needs a flash model that succeeds only after a chosen number of pulses per address. The same holds for the pre-programming precondition, the resume-at-failing-address walk and the exhaustion of both attempt limits.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_PSETUP, S_PDATA, S_PPULSE, S_PVCMD, S_PREAD, S_PCHECK,
        S_ESETUP, S_ECMD, S_EPULSE, S_EVCMD, S_EREAD, S_ECHECK, S_FINISH
    } seq_state_t;

    typedef enum logic [2:0] {
        B_IDLE, B_SETUP, B_STROBE, B_HOLD, B_READ
    } bus_phase_t;

    localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
    localparam logic [7:0] CMD_PROG_VERIFY = 8'hC0;
    localparam logic [7:0] CMD_ERASE       = 8'h20;
    localparam logic [7:0] CMD_ERASE_VERIFY = 8'hA0;
endpackage

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
    parameter int MAX_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic [$clog2(MAX_LEN+1)-1:0] len,
    output logic expired
);
    localparam int CW = $clog2(MAX_LEN + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == len - 1'b1);
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int T_SETUP  = 2,
    parameter int T_WE_LOW = 3,
    parameter int T_HOLD   = 2,
    parameter int T_ACCESS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);
    localparam int TMAX = (T_SETUP > T_WE_LOW ? T_SETUP : T_WE_LOW) >
                          (T_HOLD > T_ACCESS ? T_HOLD : T_ACCESS) ?
                          (T_SETUP > T_WE_LOW ? T_SETUP : T_WE_LOW) :
                          (T_HOLD > T_ACCESS ? T_HOLD : T_ACCESS);
    localparam int CW = $clog2(TMAX + 1);

    bus_phase_t ph;
    logic [CW-1:0] cnt;
    logic          last;

    always_comb begin
        unique case (ph)
            B_SETUP:  last = (cnt == CW'(T_SETUP - 1));
            B_STROBE: last = (cnt == CW'(T_WE_LOW - 1));
            B_HOLD:   last = (cnt == CW'(T_HOLD - 1));
            B_READ:   last = (cnt == CW'(T_ACCESS - 1));
            default:  last = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph       <= B_IDLE;
            cnt      <= '0;
            bus_addr <= '0;
            dq_out   <= '0;
            rdata    <= '0;
        end else begin
            cnt <= last ? '0 : cnt + 1'b1;
            unique case (ph)
                B_IDLE: begin
                    cnt <= '0;
                    if (req) begin
                        bus_addr <= addr;
                        dq_out   <= wdata;
                        ph       <= is_read ? B_READ : B_SETUP;
                    end
                end
                B_SETUP:  if (last) ph <= B_STROBE;
                B_STROBE: if (last) ph <= B_HOLD;
                B_HOLD:   if (last) ph <= B_IDLE;
                B_READ: if (last) begin
                    rdata <= dq_in;
                    ph    <= B_IDLE;
                end
                default: ph <= B_IDLE;
            endcase
        end
    end

    assign ack   = last && (ph == B_HOLD || ph == B_READ);
    assign ce_n  = (ph == B_IDLE);
    assign we_n  = (ph != B_STROBE);
    assign oe_n  = (ph != B_READ);
    assign dq_oe = (ph == B_SETUP || ph == B_STROBE || ph == B_HOLD);

    logic [CW:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     low_run <= '0;
        else if (!we_n) low_run <= low_run + 1'b1;
        else            low_run <= '0;
    end

    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n); // R8
    AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(bus_addr) && $stable(dq_out))); // R8
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n) && low_run == (CW+1)'(T_WE_LOW - 1)) |=> we_n); // R8
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!dq_oe && !ce_n)); // R9
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int T_SETUP       = 2,
    parameter int T_WE_LOW      = 3,
    parameter int T_HOLD        = 2,
    parameter int T_ACCESS      = 4,
    parameter int T_PROG_PULSE  = 500,
    parameter int T_ERASE_PULSE = 5000,
    parameter int PROG_TRIES    = 25,
    parameter int ERASE_TRIES   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [DATA_W-1:0] fl_dq_in
);
    localparam int PMAX = T_PROG_PULSE > T_ERASE_PULSE ? T_PROG_PULSE : T_ERASE_PULSE;
    localparam int TW   = $clog2(PMAX + 1);
    localparam int PTW  = $clog2(PROG_TRIES);
    localparam int ETW  = $clog2(ERASE_TRIES);

    seq_state_t state, nxt;
    logic              prep;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] target;
    logic [PTW-1:0]    ptries;
    logic [ETW-1:0]    etries;

    logic              b_req, b_read, b_ack;
    logic [DATA_W-1:0] b_wdata, b_rdata;
    logic              t_run, t_exp;
    logic [TW-1:0]     t_len;

    wire at_top   = (cur_addr == {ADDR_W{1'b1}});
    wire p_match  = (b_rdata == target);
    wire e_match  = (b_rdata == {DATA_W{1'b1}});
    wire p_limit  = (ptries == PTW'(PROG_TRIES - 1));
    wire e_limit  = (etries == ETW'(ERASE_TRIES - 1));

    flash_bus_cycle #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_SETUP(T_SETUP),
        .T_WE_LOW(T_WE_LOW), .T_HOLD(T_HOLD), .T_ACCESS(T_ACCESS)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .req(b_req), .is_read(b_read),
        .addr(cur_addr), .wdata(b_wdata), .ack(b_ack), .rdata(b_rdata),
        .ce_n(fl_ce_n), .oe_n(fl_oe_n), .we_n(fl_we_n), .bus_addr(fl_addr),
        .dq_out(fl_dq_out), .dq_oe(fl_dq_oe), .dq_in(fl_dq_in)
    );

    flash_pulse_timer #(.MAX_LEN(PMAX)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(t_run), .len(t_len), .expired(t_exp)
    );

    // next state and bus requests
    always_comb begin
        nxt     = state;
        b_req   = 1'b0;
        b_read  = 1'b0;
        b_wdata = '0;
        t_run   = 1'b0;
        t_len   = TW'(T_PROG_PULSE);
        unique case (state)
            S_IDLE:   if (start) nxt = S_PSETUP;
            S_PSETUP: begin b_req = 1'b1; b_wdata = DATA_W'(CMD_PROG_SETUP); if (b_ack) nxt = S_PDATA; end
            S_PDATA:  begin b_req = 1'b1; b_wdata = target; if (b_ack) nxt = S_PPULSE; end
            S_PPULSE: begin t_run = 1'b1; if (t_exp) nxt = S_PVCMD; end
            S_PVCMD:  begin b_req = 1'b1; b_wdata = DATA_W'(CMD_PROG_VERIFY); if (b_ack) nxt = S_PREAD; end
            S_PREAD:  begin b_req = 1'b1; b_read = 1'b1; if (b_ack) nxt = S_PCHECK; end
            S_PCHECK: begin
                if (p_match) nxt = !prep ? S_FINISH : (at_top ? S_ESETUP : S_PSETUP);
                else         nxt = p_limit ? S_FINISH : S_PSETUP;
            end
            S_ESETUP: begin b_req = 1'b1; b_wdata = DATA_W'(CMD_ERASE); if (b_ack) nxt = S_ECMD; end
            S_ECMD:   begin b_req = 1'b1; b_wdata = DATA_W'(CMD_ERASE); if (b_ack) nxt = S_EPULSE; end
            S_EPULSE: begin t_run = 1'b1; t_len = TW'(T_ERASE_PULSE); if (t_exp) nxt = S_EVCMD; end
            S_EVCMD:  begin b_req = 1'b1; b_wdata = DATA_W'(CMD_ERASE_VERIFY); if (b_ack) nxt = S_EREAD; end
            S_EREAD:  begin b_req = 1'b1; b_read = 1'b1; if (b_ack) nxt = S_ECHECK; end
            S_ECHECK: begin
                if (e_match) nxt = at_top ? S_FINISH : S_EVCMD;
                else         nxt = e_limit ? S_FINISH : S_ESETUP;
            end
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // state register and sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            prep      <= 1'b0;
            cur_addr  <= '0;
            target    <= '0;
            ptries    <= '0;
            etries    <= '0;
            fail      <= 1'b0;
            fail_addr <= '0;
            done      <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == S_FINISH);
            unique case (state)
                S_IDLE: if (start) begin
                    prep      <= op;
                    cur_addr  <= op ? '0 : addr_in;
                    target    <= op ? '0 : data_in;
                    ptries    <= '0;
                    etries    <= '0;
                    fail      <= 1'b0;
                    fail_addr <= '0;
                end
                S_PCHECK: begin
                    if (p_match) begin
                        if (prep) begin
                            ptries   <= '0;
                            cur_addr <= cur_addr + 1'b1;
                            if (at_top) prep <= 1'b0;
                        end
                    end else if (p_limit) begin
                        fail      <= 1'b1;
                        fail_addr <= cur_addr;
                    end else begin
                        ptries <= ptries + 1'b1;
                    end
                end
                S_ECHECK: begin
                    if (e_match) begin
                        if (!at_top) cur_addr <= cur_addr + 1'b1;
                    end else if (e_limit) begin
                        fail      <= 1'b1;
                        fail_addr <= cur_addr;
                    end else begin
                        etries <= etries + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy = (state != S_IDLE);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_PTRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptries < PTW'(PROG_TRIES)); // R3
    AST_ETRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        etries < ETW'(ERASE_TRIES)); // R7
    AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(state == S_IDLE && start)) |=> (fail && $stable(fail_addr))); // R10
endmodule

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;
    localparam int AW = 4;
    localparam int N = 1 << AW;
    localparam int TPP = 6;
    localparam int TEP = 10;

    logic clk = 0, rst_n = 0, start = 0, op = 0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0] data_in = '0;
    logic busy, done, fail, ce_n, oe_n, we_n, dq_oe;
    logic [AW-1:0] fail_addr, fl_addr;
    logic [7:0] dq_out, dq_in;

    always #10 clk = ~clk;

    flash_prog_seq #(.ADDR_W(AW), .DATA_W(8), .T_SETUP(1), .T_WE_LOW(2), .T_HOLD(1),
        .T_ACCESS(2), .T_PROG_PULSE(TPP), .T_ERASE_PULSE(TEP),
        .PROG_TRIES(25), .ERASE_TRIES(1000)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr_in(addr_in),
        .data_in(data_in), .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
        .fl_ce_n(ce_n), .fl_oe_n(oe_n), .fl_we_n(we_n), .fl_addr(fl_addr),
        .fl_dq_out(dq_out), .fl_dq_oe(dq_oe), .fl_dq_in(dq_in));

    // flash model: cells only take a program or erase after a set number of pulses
    logic [7:0] mem [N];
    int need_p [N];
    int need_e [N];
    int pcnt [N];
    int ecnt, vcnt, evcnt, seq_err, prep_err, gap_err, mode, setup_addr, pre_order_err, last_pa;
    time last_pulse_t;

    assign dq_in = mem[fl_addr];

    always @(posedge we_n) begin
        if (rst_n && !ce_n) begin
            if (mode == 1) begin
                if (int'(fl_addr) != setup_addr) seq_err++;
                pcnt[fl_addr]++;
                last_pulse_t = $time;
                if (pcnt[fl_addr] >= need_p[fl_addr]) mem[fl_addr] = mem[fl_addr] & dq_out;
                if (dq_out == 8'h00) begin
                    if (int'(fl_addr) < last_pa) pre_order_err++;
                    last_pa = int'(fl_addr);
                end
                mode = 0;
            end else if (mode == 2) begin
                if (dq_out == 8'h20) begin
                    if (ecnt == 0)
                        for (int a = 0; a < N; a++) if (mem[a] != 8'h00) prep_err++;
                    ecnt++;
                    last_pulse_t = $time;
                    for (int a = 0; a < N; a++) if (ecnt >= need_e[a]) mem[a] = 8'hFF;
                end else seq_err++;
                mode = 0;
            end else begin
                case (dq_out)
                    8'h40: begin mode = 1; setup_addr = int'(fl_addr); end
                    8'h20: mode = 2;
                    8'hC0: begin vcnt++; if ($time - last_pulse_t < TPP*20) gap_err++; end
                    8'hA0: begin evcnt++; if (ecnt == 0) seq_err++; end
                    default: seq_err++;
                endcase
            end
        end
    end

    int checks = 0, fails = 0;
    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int a = 0; a < N; a++) begin pcnt[a] = 0; need_p[a] = 1; need_e[a] = 1; end
        ecnt = 0; vcnt = 0; evcnt = 0; seq_err = 0; prep_err = 0; gap_err = 0;
        mode = 0; last_pa = -1; pre_order_err = 0;
    endtask

    task automatic run_op(input logic o, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        start = 1; op = o; addr_in = a; data_in = d;
        @(negedge clk);
        start = 0;
        while (!done) @(negedge clk);
    endtask

    function automatic int exp_pulses(input int need);
        return need <= 25 ? need : 25;
    endfunction

    function automatic int exp_verifies();
        int a = 0, c = 0;
        for (int p = 1; p <= 1000 && a < N; p++) begin
            while (a < N) begin
                c++;
                if (need_e[a] <= p) a++;
                else break;
            end
        end
        return c;
    endfunction

    function automatic int max_need_e();
        int m = 0;
        for (int a = 0; a < N; a++) if (need_e[a] > m) m = need_e[a];
        return m;
    endfunction

    initial begin
        int cyc = 0;
        while (cyc < 180000) begin @(posedge clk); cyc++; end
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int sd, a, nd, all_ff;
        logic [7:0] d;
        sd = $urandom(1234);
        clear_model();
        for (int i = 0; i < N; i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(ce_n && oe_n && we_n && !dq_oe, "R1 pins", {ce_n, oe_n, we_n, dq_oe}, 4'b1110);
        chk(!busy && !done && !fail, "R1 status", {busy, done, fail}, 0);

        // R2 single-pulse program
        clear_model(); mem[3] = 8'hFF;
        run_op(0, 3, 8'h5A);
        chk(!fail && mem[3] == 8'h5A, "R2 data", mem[3], 8'h5A);
        chk(pcnt[3] == 1 && vcnt == 1, "R2 attempt count", vcnt, 1);
        chk(seq_err == 0 && gap_err == 0, "R2 order/pulse", seq_err + gap_err, 0);
        chk(!busy, "R10 idle after done", busy, 0);

        // R3 boundary: 25 attempts succeed, 26 fail
        clear_model(); mem[7] = 8'hFF; need_p[7] = 25;
        run_op(0, 7, 8'h3C);
        chk(!fail && pcnt[7] == 25, "R3 25th attempt ok", pcnt[7], 25);
        clear_model(); mem[9] = 8'hFF; need_p[9] = 26;
        run_op(0, 9, 8'h81);
        chk(fail && fail_addr == 9, "R3 fail address", fail_addr, 9);
        chk(pcnt[9] == 25, "R3 attempt limit", pcnt[9], 25);
        // R10 fail held
        repeat (5) @(negedge clk);
        chk(fail && fail_addr == 9, "R10 fail held", fail, 1);

        // R2 R3 random programs
        for (int i = 0; i < 12; i++) begin
            clear_model();
            a = $urandom_range(N - 1);
            d = 8'($urandom);
            nd = $urandom_range(30, 1);
            mem[a] = 8'hFF; need_p[a] = nd;
            run_op(0, AW'(a), d);
            chk(pcnt[a] == exp_pulses(nd), "R3 random attempts", pcnt[a], exp_pulses(nd));
            chk(fail == (nd > 25), "R3 random outcome", fail, nd > 25);
            chk(vcnt == exp_pulses(nd) && seq_err == 0 && gap_err == 0, "R2 random sequence",
                vcnt, exp_pulses(nd));
        end

        // R10 start while busy ignored
        clear_model(); mem[1] = 8'hFF; mem[2] = 8'hFF; need_p[1] = 3;
        @(negedge clk); start = 1; op = 0; addr_in = 1; data_in = 8'h12;
        @(negedge clk); start = 0;
        repeat (4) @(negedge clk);
        start = 1; op = 1; addr_in = 2; data_in = 8'h00;
        @(negedge clk); start = 0;
        while (!done) @(negedge clk);
        chk(pcnt[2] == 0 && ecnt == 0 && mem[1] == 8'h12, "R10 start ignored", pcnt[2] + ecnt, 0);
        chk(!fail, "R10 fail cleared by start", fail, 0);

        // R4 R5 R6 random erase
        for (int k = 0; k < 3; k++) begin
            clear_model();
            for (int i = 0; i < N; i++) begin
                mem[i] = 8'($urandom);
                need_p[i] = $urandom_range(2, 1);
                need_e[i] = $urandom_range(6, 1);
            end
            run_op(1, 0, 0);
            all_ff = 1;
            for (int i = 0; i < N; i++) if (mem[i] != 8'hFF) all_ff = 0;
            chk(!fail && all_ff == 1, "R6 erased", all_ff, 1);
            chk(prep_err == 0 && pre_order_err == 0, "R4 preprogram", prep_err + pre_order_err, 0);
            chk(ecnt == max_need_e() && seq_err == 0, "R5 erase attempts", ecnt, max_need_e());
            chk(evcnt == exp_verifies(), "R6 verify walk", evcnt, exp_verifies());
        end

        // R7 erase limit
        clear_model();
        need_e[5] = 2000;
        run_op(1, 0, 0);
        chk(fail && fail_addr == 5, "R7 fail address", fail_addr, 5);
        chk(ecnt == 1000, "R7 attempt limit", ecnt, 1000);
        chk(evcnt == 6 + 999, "R6 resume at failing address", evcnt, 1005);
        chk(mem[4] == 8'hFF && mem[6] == 8'hFF, "R5 erase effect", mem[6], 8'hFF);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule